// File: doc/BRIEF.md
# Pin I/O Controller with Level and Edge Interrupt Detection

A register-mapped general purpose pin controller for up to 32 pins, attached to a simple single-cycle 32-bit read/write bus. Every pin has an output data bit and an output enable bit. When the enable bit is 0 the pin is an input. Pin inputs are first passed through a two-flop synchronizer. The synchronized value can be read back and is used for all interrupt detection.

Each pin has two kinds of interrupt source. The first is a level source: it is pending while the synchronized input differs from a per-pin polarity bit. This source is never latched. The second is an edge source: a rising or falling edge, chosen per pin, sets a sticky event bit, which software clears by writing 1 to it. Each source kind has its own per-pin mask. All unmasked pending sources are ORed into one summary status bit. That bit drives the single interrupt output, but only when the top-level enable bit is set.

Software reads the summary status, reads the event and input registers to find the cause, and then clears the edge events it has handled.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every register reads 0, `pin_oe_o` and `pin_o` are all 0 and `irq_o` is 0.
- R2: Output data (offset 0x44) and output enable (offset 0x48) are read/write, and bit n of each belongs to pin n. Register bits at or above NPINS read 0. `pin_oe_o` follows the enable register. `pin_o[n]` equals data bit n when enable bit n is 1 and is 0 otherwise.
- R3: Input data (offset 0x40) returns the pin levels after a two-flop synchronizer. A level held on `pin_i` across two rising clock edges is visible there after the second edge. Writes to this offset change nothing.
- R4: Level polarity (offset 0x50) and level mask (offset 0x54) are read/write. A level interrupt is pending for pin n while (input[n] XOR polarity[n]) AND mask[n] is 1, so a polarity bit of 1 means active-low. This source is not latched: it clears as soon as the input returns to its inactive level.
- R5: Edge polarity (offset 0x64) is read/write. A value of 0 selects rising edges and 1 selects falling edges. A selected edge on the synchronized input sets bit n of the event register (offset 0x58). The bit then stays set, whatever the mask says.
- R6: Writing 1 to an event bit clears it. Writing 0 leaves it unchanged. If a new edge arrives in the same cycle as a clear of the same bit, the bit stays set.
- R7: Edge mask (offset 0x5C) is read/write. An edge interrupt is pending for pin n while event[n] AND edge_mask[n] is 1.
- R8: Bit 0 of the status register (offset 0x00) reads 1 when any pin has a level or edge interrupt pending. The status register cannot be written.
- R9: `irq_o` is 1 exactly when status bit 0 is 1 and bit 0 of the enable register (offset 0x04) is 1. Only bit 0 of the enable register is stored.
- R10: Every other offset reads 0 and ignores writes, and a write there disturbs no mapped register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the same cycle as a read strobe, else 0 |
| pin_i | input | NPINS | Pad input levels (asynchronous) |
| pin_o | output | NPINS | Pad output values |
| pin_oe_o | output | NPINS | Pad output enables |
| irq_o | output | 1 | Summary interrupt |

## Verification
The level path is swept over every combination of input pattern, polarity and mask on a four-pin build. A wrong XOR sense, a missing mask or an inverted polarity shows up as a status mismatch on some pin. The edge path is swept over every pair of old and new input patterns for every edge polarity, with a mask that varies alongside it. This separates rising from falling detection, latching from masking, and one pin from its neighbours. Directed sequences put a clear into the exact cycle a new edge lands, write zeros to the event register, drop the top-level enable, and write to unmapped and read-only offsets, so that the clear-versus-set priority and the write protection are each seen on their own.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int BUS_AW = 8;

  localparam logic [BUS_AW-1:0] OFS_STAT = 8'h00;
  localparam logic [BUS_AW-1:0] OFS_GEN  = 8'h04;
  localparam logic [BUS_AW-1:0] OFS_DIN  = 8'h40;
  localparam logic [BUS_AW-1:0] OFS_DOUT = 8'h44;
  localparam logic [BUS_AW-1:0] OFS_OE   = 8'h48;
  localparam logic [BUS_AW-1:0] OFS_LPOL = 8'h50;
  localparam logic [BUS_AW-1:0] OFS_LMSK = 8'h54;
  localparam logic [BUS_AW-1:0] OFS_EVT  = 8'h58;
  localparam logic [BUS_AW-1:0] OFS_EMSK = 8'h5C;
  localparam logic [BUS_AW-1:0] OFS_EPOL = 8'h64;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_STAT, SEL_GEN, SEL_DIN, SEL_DOUT, SEL_OE,
    SEL_LPOL, SEL_LMSK, SEL_EVT, SEL_EMSK, SEL_EPOL
  } reg_sel_e;

  function automatic reg_sel_e decode(input logic [BUS_AW-1:0] a);
    case (a)
      OFS_STAT: decode = SEL_STAT;
      OFS_GEN:  decode = SEL_GEN;
      OFS_DIN:  decode = SEL_DIN;
      OFS_DOUT: decode = SEL_DOUT;
      OFS_OE:   decode = SEL_OE;
      OFS_LPOL: decode = SEL_LPOL;
      OFS_LMSK: decode = SEL_LMSK;
      OFS_EVT:  decode = SEL_EVT;
      OFS_EMSK: decode = SEL_EMSK;
      OFS_EPOL: decode = SEL_EPOL;
      default:  decode = SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_evt.sv
module gpio_edge_evt #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] smp_i,
  input  logic [W-1:0] pol_i,   // 1 = falling
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] evt_o
);
  logic [W-1:0] prv_q, evt_q, hit;

  always_comb hit = (smp_i & ~prv_q & ~pol_i) | (~smp_i & prv_q & pol_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prv_q <= '0;
      evt_q <= '0;
    end else begin
      prv_q <= smp_i;
      evt_q <= (evt_q & ~clr_i) | hit;  // set beats clear
    end
  end

  assign evt_o = evt_q;

  assert_evt_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(evt_q) & ~$past(clr_i) & ~evt_q) == '0));

  assert_edge_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(hit) & ~evt_q) == '0));
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_irq_pkg::*;
#(
  parameter int W  = 32,
  parameter int DW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [BUS_AW-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [W-1:0]      din_i,
  input  logic [W-1:0]      evt_i,
  input  logic              stat_i,
  output logic [W-1:0]      dout_o,
  output logic [W-1:0]      oe_o,
  output logic [W-1:0]      lpol_o,
  output logic [W-1:0]      lmsk_o,
  output logic [W-1:0]      emsk_o,
  output logic [W-1:0]      epol_o,
  output logic              gen_o,
  output logic [W-1:0]      evt_clr_o
);
  reg_sel_e     sel;
  logic         wr, rd;
  logic [W-1:0] wd;
  logic [W-1:0] dout_q, oe_q, lpol_q, lmsk_q, emsk_q, epol_q;
  logic         gen_q;

  assign sel = decode(addr_i);
  assign wr  = req_i & we_i;
  assign rd  = req_i & ~we_i;
  assign wd  = wdata_i[W-1:0];

  if (W < DW) begin : g_unused
    logic unused_wd;
    assign unused_wd = ^wdata_i[DW-1:W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_q <= '0;
      oe_q   <= '0;
      lpol_q <= '0;
      lmsk_q <= '0;
      emsk_q <= '0;
      epol_q <= '0;
      gen_q  <= 1'b0;
    end else if (wr) begin
      case (sel)
        SEL_GEN:  gen_q  <= wd[0];
        SEL_DOUT: dout_q <= wd;
        SEL_OE:   oe_q   <= wd;
        SEL_LPOL: lpol_q <= wd;
        SEL_LMSK: lmsk_q <= wd;
        SEL_EMSK: emsk_q <= wd;
        SEL_EPOL: epol_q <= wd;
        default: ;
      endcase
    end
  end

  assign evt_clr_o = (wr && sel == SEL_EVT) ? wd : '0;

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      case (sel)
        SEL_STAT: rdata_o = DW'(stat_i);
        SEL_GEN:  rdata_o = DW'(gen_q);
        SEL_DIN:  rdata_o = DW'(din_i);
        SEL_DOUT: rdata_o = DW'(dout_q);
        SEL_OE:   rdata_o = DW'(oe_q);
        SEL_LPOL: rdata_o = DW'(lpol_q);
        SEL_LMSK: rdata_o = DW'(lmsk_q);
        SEL_EVT:  rdata_o = DW'(evt_i);
        SEL_EMSK: rdata_o = DW'(emsk_q);
        SEL_EPOL: rdata_o = DW'(epol_q);
        default:  rdata_o = '0;
      endcase
    end
  end

  assign dout_o = dout_q;
  assign oe_o   = oe_q;
  assign lpol_o = lpol_q;
  assign lmsk_o = lmsk_q;
  assign emsk_o = emsk_q;
  assign epol_o = epol_q;
  assign gen_o  = gen_q;

  assert_unmapped_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && addr_i != OFS_STAT && addr_i != OFS_GEN && addr_i[7:6] != 2'b01)
      |-> (rdata_o == '0));

  assert_cfg_stable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wr) |-> ($stable(oe_q) && $stable(dout_q)));
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int DW    = 32,
  parameter int SYNC  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [BUS_AW-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [NPINS-1:0]  pin_i,
  output logic [NPINS-1:0]  pin_o,
  output logic [NPINS-1:0]  pin_oe_o,
  output logic              irq_o
);
  logic [NPINS-1:0] din, evt, evt_clr;
  logic [NPINS-1:0] dout, oe, lpol, lmsk, emsk, epol;
  logic [NPINS-1:0] pend_lvl, pend_edg;
  logic             gen, stat;

  gpio_sync #(.W(NPINS), .STAGES(SYNC)) u_sync (
    .clk_i, .rst_ni, .d_i(pin_i), .q_o(din)
  );

  gpio_edge_evt #(.W(NPINS)) u_evt (
    .clk_i, .rst_ni, .smp_i(din), .pol_i(epol), .clr_i(evt_clr), .evt_o(evt)
  );

  gpio_regs #(.W(NPINS), .DW(DW)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .din_i(din), .evt_i(evt), .stat_i(stat),
    .dout_o(dout), .oe_o(oe), .lpol_o(lpol), .lmsk_o(lmsk),
    .emsk_o(emsk), .epol_o(epol), .gen_o(gen), .evt_clr_o(evt_clr)
  );

  assign pend_lvl = (din ^ lpol) & lmsk;
  assign pend_edg = evt & emsk;
  assign stat     = |(pend_lvl | pend_edg);
  assign irq_o    = stat & gen;
  assign pin_o    = dout & oe;
  assign pin_oe_o = oe;

  assert_irq_gated_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (gen && (pend_lvl != '0 || pend_edg != '0)));
endmodule

// File: tb/tb_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_irq_ctrl;
  localparam int NP = 4;
  localparam int DW = 32;
  localparam logic [7:0] A_STAT = 8'h00, A_GEN = 8'h04, A_DIN = 8'h40,
    A_DOUT = 8'h44, A_OE = 8'h48, A_LPOL = 8'h50, A_LMSK = 8'h54,
    A_EVT = 8'h58, A_EMSK = 8'h5C, A_EPOL = 8'h64;

  logic          clk = 1'b0, rst_n = 1'b0, req = 1'b0, we = 1'b0;
  logic [7:0]    addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [NP-1:0] pins = '0;
  logic [NP-1:0] pin_o, pin_oe;
  logic          irq;
  int vec = 0, bad = 0;
  bit done = 0;

  gpio_irq_ctrl #(.NPINS(NP), .DW(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pin_i(pins), .pin_o(pin_o),
    .pin_oe_o(pin_oe), .irq_o(irq)
  );

  always #4 clk = ~clk;

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    #1 d = rdata;
    req = 0;
  endtask

  task automatic setpins(logic [NP-1:0] v);
    @(negedge clk); pins = v;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      bad++; vec++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [7:0] all_a [10];
    all_a = '{A_STAT, A_GEN, A_DIN, A_DOUT, A_OE, A_LPOL, A_LMSK, A_EVT, A_EMSK, A_EPOL};
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R1 reset state
    for (int i = 0; i < 10; i++) begin
      rd(all_a[i], r); chk("R1 reset read", r, 0);
    end
    chk("R1 pin_oe_o", 32'(pin_oe), 0);
    chk("R1 pin_o", 32'(pin_o), 0);
    chk("R1 irq_o", 32'(irq), 0);

    // R2 output data / enable sweep
    for (int d = 0; d < 16; d++) begin
      for (int e = 0; e < 16; e++) begin
        wr(A_DOUT, 32'hFFFF_FFF0 | d);
        wr(A_OE, 32'hABCD_EF00 | e);
        rd(A_DOUT, r); chk("R2 dout readback", r, d);
        rd(A_OE, r);   chk("R2 oe readback", r, e);
        chk("R2 pin_oe_o", 32'(pin_oe), e);
        chk("R2 pin_o", 32'(pin_o), d & e);
      end
    end
    wr(A_DOUT, 0); wr(A_OE, 0);

    // R3/R4/R8/R9 level sweep
    wr(A_GEN, 32'hFFFF_FFFF);
    rd(A_GEN, r); chk("R9 enable bit0 only", r, 1);
    for (int p = 0; p < 16; p++) begin
      for (int m = 0; m < 16; m++) begin
        wr(A_LPOL, p); wr(A_LMSK, m);
        for (int v = 0; v < 16; v++) begin
          logic exp_st;
          setpins(4'(v));
          exp_st = (((v ^ p) & m) != 0);
          rd(A_STAT, r); chk("R4 R8 level status", r, 32'(exp_st));
          chk("R9 irq_o follows status", 32'(irq), 32'(exp_st));
          if (m == 0) begin
            rd(A_DIN, r); chk("R3 input data", r, v);
          end
        end
      end
    end
    // R4 not latched: drive active then inactive
    wr(A_LPOL, 0); wr(A_LMSK, 4'h1);
    setpins(4'h1);
    rd(A_STAT, r); chk("R4 active", r, 1);
    setpins(4'h0);
    rd(A_STAT, r); chk("R4 not latched", r, 0);
    // R9 enable off hides pending
    setpins(4'h1);
    wr(A_GEN, 0);
    rd(A_STAT, r); chk("R9 status with enable off", r, 1);
    chk("R9 irq_o gated", 32'(irq), 0);
    wr(A_LMSK, 0); wr(A_GEN, 1);
    setpins(4'h0);

    // R3 sync latency: visible only after second edge
    @(negedge clk); pins = 4'h5;
    @(negedge clk); req = 1; we = 0; addr = A_DIN; #1 r = rdata; req = 0;
    chk("R3 not yet after one edge", r, 0);
    @(negedge clk); req = 1; we = 0; addr = A_DIN; #1 r = rdata; req = 0;
    chk("R3 visible after two edges", r, 5);
    setpins(4'h0);

    // R5/R6/R7 edge sweep
    for (int ep = 0; ep < 16; ep++) begin
      logic [3:0] em;
      em = 4'(ep ^ 9);
      wr(A_EPOL, ep); wr(A_EMSK, em);
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          logic [3:0] ev;
          setpins(4'(a));
          wr(A_EVT, 32'hF);
          setpins(4'(b));
          ev = 4'((a & ~b & ep) | (~a & b & ~ep));
          rd(A_EVT, r); chk("R5 event latch", r, 32'(ev));
          rd(A_STAT, r); chk("R7 edge status", r, 32'((ev & em) != 0));
        end
      end
    end
    wr(A_EMSK, 0); wr(A_EPOL, 0);
    setpins(4'h0);
    wr(A_EVT, 32'hF);

    // R5 stays latched after input returns
    setpins(4'h2); setpins(4'h0);
    rd(A_EVT, r); chk("R5 event sticky", r, 2);
    // R6 write 0 no effect, write 1 clears only that bit
    setpins(4'h8);
    wr(A_EVT, 0);
    rd(A_EVT, r); chk("R6 write zero keeps", r, 32'hA);
    wr(A_EVT, 2);
    rd(A_EVT, r); chk("R6 write one clears bit", r, 8);
    setpins(4'h0);
    wr(A_EVT, 32'hF);
    // R6 collision: clear lands in the edge-set cycle
    @(negedge clk); pins = 4'h1;
    @(negedge clk);
    @(negedge clk); req = 1; we = 1; addr = A_EVT; wdata = 1;
    @(negedge clk); req = 0; we = 0;
    rd(A_EVT, r); chk("R6 new edge wins over clear", r, 1);
    wr(A_EVT, 1);
    rd(A_EVT, r); chk("R6 later clear works", r, 0);
    setpins(4'h0);
    wr(A_EVT, 32'hF);

    // R10 unmapped and read-only writes
    wr(A_OE, 4'h3); wr(A_LPOL, 4'h6); wr(A_EMSK, 4'h9);
    wr(8'h08, 32'hFFFF_FFFF); wr(8'h4C, 32'hFFFF_FFFF);
    wr(8'hFC, 32'hFFFF_FFFF); wr(8'h60, 32'hFFFF_FFFF);
    wr(A_DIN, 32'hFFFF_FFFF); wr(A_STAT, 32'hFFFF_FFFF);
    rd(8'h08, r); chk("R10 unmapped 0x08", r, 0);
    rd(8'h4C, r); chk("R10 unmapped 0x4C", r, 0);
    rd(8'hFC, r); chk("R10 unmapped 0xFC", r, 0);
    rd(8'h60, r); chk("R10 unmapped 0x60", r, 0);
    rd(A_DIN, r); chk("R3 input not writable", r, 0);
    rd(A_STAT, r); chk("R8 status not writable", r, 0);
    rd(A_OE, r); chk("R10 oe undisturbed", r, 3);
    rd(A_LPOL, r); chk("R10 lpol undisturbed", r, 6);
    rd(A_EMSK, r); chk("R10 emsk undisturbed", r, 9);
    rd(A_DOUT, r); chk("R10 dout undisturbed", r, 0);
    rd(A_LMSK, r); chk("R10 lmsk undisturbed", r, 0);
    rd(A_EPOL, r); chk("R10 epol undisturbed", r, 0);
    rd(A_GEN, r); chk("R10 enable undisturbed", r, 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule